// File: doc/BRIEF.md
# Flash Byte Program-Verify Sequencer

This block writes a single byte into a flash array with repeated program pulses and read-back checks. A one-cycle start strobe latches a target address and a data byte. The sequencer then raises the programming supply enable, waits a settling interval, and selects the erase/program block that holds the address. It applies a program pulse and switches the array into verify mode. On the last verify cycle it compares the byte read back with the byte it meant to write.

On a mismatch, verify mode is dropped and the failure counter advances. The next pulse is twice as long as the previous one, limited to the largest value the length register can hold. After six failed verifies the sequencer gives up. The controls are then switched off and an error flag is raised. On a match, the controls are released one at a time and a done flag is raised. Either flag lasts one cycle, and the sequencer then returns to idle.

Top module: `flash_pv_seq`

## Requirements
- R1: After reset all control outputs, the flags, busy and the failure count are 0.
- R2: A start accepted in idle raises the supply enable at once. The supply is held for SETUP_CYC cycles with no block selected. The one-hot block select then comes up, with the block index taken from the top log2(NBLK) address bits. It is set one cycle before the first pulse and stays set for all pulses and verifies.
- R3: The first program pulse lasts INIT_PULSE cycles. The program and verify controls are never high in the same cycle.
- R4: Each retry pulse is twice the length of the previous pulse, saturating at 2^PW-1 cycles.
- R5: Verify is held high for VFY_CYC cycles after each pulse. The read-back byte is compared with the intended byte on the last of those cycles, and equality means pass.
- R6: The failure count reads 0 in the first busy cycle of each operation and grows by exactly one per failed verify.
- R7: After a failed verify, the verify control is low for at least one cycle before the next pulse begins.
- R8: The sixth failed verify ends the operation with an error. The failure count never exceeds 6, and no pulse follows the sixth failure.
- R9: On pass, the verify control drops first. The block select clears one cycle later, the supply enable one cycle after that, and done is raised in the following cycle.
- R10: On error, the block select and the supply enable clear in the same cycle, and the error flag is raised in the next cycle.
- R11: Done and error are never high together. Each lasts exactly one cycle, and busy is low in the cycle after.
- R12: A start strobe while busy is ignored. The latched address, the data and the outcome of the running operation are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, acted on only in idle |
| addr_i | input | AW | Target byte address |
| data_i | input | 8 | Byte to be written |
| rdata_i | input | 8 | Byte read back from the array |
| supply_o | output | 1 | Programming supply enable |
| prog_o | output | 1 | Program pulse control |
| verify_o | output | 1 | Verify mode control |
| blk_sel_o | output | NBLK | One-hot block select |
| addr_o | output | AW | Latched address presented to the array |
| wdata_o | output | 8 | Latched data presented to the array |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pass flag |
| err_o | output | 1 | One-cycle error flag |
| fail_cnt_o | output | CW | Failed verifies in the current operation |

## Verification
Every address of an 8-bit space is swept. Each address demands as many cumulative pulse cycles as its own value before the array read-back matches, so the sweep falls into every possible pass count from one pulse to six, and then into the error path. The pulse lengths seen at the ports tell doubling apart from saturation, and the operations that need five or six pulses are the only ones that reach the saturated length. One address writes the erased value, which tells a sequencer that checks only after a pulse from one that checks before it. Every eighth operation receives a stray start with a different address while busy, which tells an ignored strobe from a relatched one.

// File: rtl/flash_pv_pkg.sv
`timescale 1ns/1ps
package flash_pv_pkg;

    // Sequencer phases; the PASS_* chain releases controls one per cycle.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SUPPLY,
        ST_SELECT,
        ST_PULSE,
        ST_VERIFY,
        ST_RETRY,
        ST_PASS_A,
        ST_PASS_B,
        ST_PASS_C,
        ST_PASS_FLAG,
        ST_NG_OFF,
        ST_NG_FLAG
    } seq_st_e;

endpackage

// File: rtl/fpv_blk_decode.sv
`timescale 1ns/1ps
module fpv_blk_decode #(
    parameter int NBLK = 4,
    localparam int BSW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic [BSW-1:0]  idx_i,
    output logic [NBLK-1:0] sel_o
);
    for (genvar i = 0; i < NBLK; i++) begin : g_sel
        assign sel_o[i] = (idx_i == BSW'(i));
    end
endmodule

// File: rtl/fpv_len_dbl.sv
`timescale 1ns/1ps
module fpv_len_dbl #(
    parameter int PW = 6
) (
    input  logic [PW-1:0] len_i,
    output logic [PW-1:0] len_o
);
    // Saturating left shift: a set top bit means the double would overflow.
    always_comb begin
        if (len_i[PW-1]) len_o = '1;
        else             len_o = {len_i[PW-2:0], 1'b0};
    end
endmodule

// File: rtl/fpv_cmp.sv
`timescale 1ns/1ps
module fpv_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] rd_i,
    input  logic [DW-1:0] wr_i,
    output logic          eq_o
);
    logic [DW-1:0] diff;
    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign diff[b] = rd_i[b] ^ wr_i[b];
    end
    assign eq_o = (diff == '0);
endmodule

// File: rtl/flash_pv_seq.sv
`timescale 1ns/1ps
module flash_pv_seq
    import flash_pv_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 8,
    parameter int NBLK       = 4,
    parameter int PW         = 6,
    parameter int INIT_PULSE = 4,
    parameter int SETUP_CYC  = 3,
    parameter int VFY_CYC    = 2,
    parameter int MAX_VERIFY = 6,
    localparam int CW  = $clog2(MAX_VERIFY + 1),
    localparam int BSW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   data_i,
    input  logic [DW-1:0]   rdata_i,
    output logic            supply_o,
    output logic            prog_o,
    output logic            verify_o,
    output logic [NBLK-1:0] blk_sel_o,
    output logic [AW-1:0]   addr_o,
    output logic [DW-1:0]   wdata_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            err_o,
    output logic [CW-1:0]   fail_cnt_o
);

    typedef struct packed {
        seq_st_e          st;
        logic             sup;
        logic             prog;
        logic             vfy;
        logic [NBLK-1:0]  blk;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic [PW-1:0]    len;
        logic [PW-1:0]    tmr;
        logic [CW-1:0]    fails;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [NBLK-1:0] dec_sel;
    logic [PW-1:0]   len_dbl;
    logic            rd_match;

    fpv_blk_decode #(.NBLK(NBLK)) u_dec (
        .idx_i (q.addr[AW-1 -: BSW]),
        .sel_o (dec_sel)
    );

    fpv_len_dbl #(.PW(PW)) u_dbl (
        .len_i (q.len),
        .len_o (len_dbl)
    );

    fpv_cmp #(.DW(DW)) u_cmp (
        .rd_i (rdata_i),
        .wr_i (q.data),
        .eq_o (rd_match)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st    = ST_SUPPLY;
                    d.sup   = 1'b1;
                    d.addr  = addr_i;
                    d.data  = data_i;
                    d.len   = PW'(INIT_PULSE);
                    d.tmr   = PW'(SETUP_CYC - 1);
                    d.fails = '0;
                end
            end
            ST_SUPPLY: begin
                if (q.tmr == '0) begin
                    d.st  = ST_SELECT;
                    d.blk = dec_sel;
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            ST_SELECT: begin
                d.st   = ST_PULSE;
                d.prog = 1'b1;
                d.tmr  = q.len - 1'b1;
            end
            ST_PULSE: begin
                if (q.tmr == '0) begin
                    d.st   = ST_VERIFY;
                    d.prog = 1'b0;
                    d.vfy  = 1'b1;
                    d.tmr  = PW'(VFY_CYC - 1);
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            ST_VERIFY: begin
                if (q.tmr == '0) begin
                    d.vfy = 1'b0;
                    if (rd_match) begin
                        d.st = ST_PASS_A;
                    end else begin
                        d.st    = ST_RETRY;
                        d.fails = q.fails + 1'b1;
                    end
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            ST_RETRY: begin
                if (q.fails == CW'(MAX_VERIFY)) begin
                    d.st  = ST_NG_OFF;
                    d.blk = '0;
                    d.sup = 1'b0;
                end else begin
                    d.st   = ST_PULSE;
                    d.prog = 1'b1;
                    d.len  = len_dbl;
                    d.tmr  = len_dbl - 1'b1;
                end
            end
            ST_PASS_A: begin
                d.st  = ST_PASS_B;
                d.blk = '0;
            end
            ST_PASS_B: begin
                d.st  = ST_PASS_C;
                d.sup = 1'b0;
            end
            ST_PASS_C:    d.st = ST_PASS_FLAG;
            ST_PASS_FLAG: d.st = ST_IDLE;
            ST_NG_OFF:    d.st = ST_NG_FLAG;
            ST_NG_FLAG:   d.st = ST_IDLE;
            default: begin
                d.st   = ST_IDLE;
                d.sup  = 1'b0;
                d.prog = 1'b0;
                d.vfy  = 1'b0;
                d.blk  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign supply_o   = q.sup;
    assign prog_o     = q.prog;
    assign verify_o   = q.vfy;
    assign blk_sel_o  = q.blk;
    assign addr_o     = q.addr;
    assign wdata_o    = q.data;
    assign busy_o     = (q.st != ST_IDLE);
    assign done_o     = (q.st == ST_PASS_FLAG);
    assign err_o      = (q.st == ST_NG_FLAG);
    assign fail_cnt_o = q.fails;

endmodule

// File: rtl/fpv_checker.sv
`timescale 1ns/1ps
module fpv_checker #(
    parameter int NBLK       = 4,
    parameter int MAX_VERIFY = 6,
    parameter int CW         = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            supply_o,
    input logic            prog_o,
    input logic            verify_o,
    input logic [NBLK-1:0] blk_sel_o,
    input logic            busy_o,
    input logic            done_o,
    input logic            err_o,
    input logic [CW-1:0]   fail_cnt_o
);

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_sel_o));

    p_pulse_powered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_o |-> (supply_o && blk_sel_o != '0));

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_o && verify_o));

    p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_cnt_o != $past(fail_cnt_o)) |->
            (fail_cnt_o == '0 || (fail_cnt_o - $past(fail_cnt_o)) == CW'(1)));

    p_verify_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_o) |-> !$past(verify_o));

    p_cnt_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_cnt_o <= CW'(MAX_VERIFY));

    p_no_pulse_at_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_cnt_o == CW'(MAX_VERIFY)) |-> !prog_o);

    p_pass_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!supply_o && !$past(supply_o) && $past(blk_sel_o) == '0));

    p_err_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(blk_sel_o) == '0 && !$past(supply_o)));

    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    p_flag_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |=> (!busy_o && !done_o && !err_o));

endmodule

bind flash_pv_seq fpv_checker #(
    .NBLK       (NBLK),
    .MAX_VERIFY (MAX_VERIFY),
    .CW         (CW)
) u_fpv_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_o   (supply_o),
    .prog_o     (prog_o),
    .verify_o   (verify_o),
    .blk_sel_o  (blk_sel_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .fail_cnt_o (fail_cnt_o)
);

// File: tb/tb_flash_pv_seq.sv
`timescale 1ns/1ps
module tb_flash_pv_seq;

    localparam int AW    = 8;
    localparam int NBLK  = 4;
    localparam int PW    = 6;
    localparam int INIT  = 4;
    localparam int SETUP = 3;
    localparam int VFY   = 2;
    localparam int MAXV  = 6;
    localparam int CW    = $clog2(MAXV + 1);
    localparam int LMAX  = (1 << PW) - 1;
    localparam int WD_LIMIT = 150000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [AW-1:0]   addr_i = '0;
    logic [7:0]      data_i = '0;
    logic [7:0]      rdata_i;
    logic            supply_o, prog_o, verify_o, busy_o, done_o, err_o;
    logic [NBLK-1:0] blk_sel_o;
    logic [AW-1:0]   addr_o;
    logic [7:0]      wdata_o;
    logic [CW-1:0]   fail_cnt_o;

    always #2.5 clk = ~clk;

    flash_pv_seq #(
        .AW(AW), .DW(8), .NBLK(NBLK), .PW(PW), .INIT_PULSE(INIT),
        .SETUP_CYC(SETUP), .VFY_CYC(VFY), .MAX_VERIFY(MAXV)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .data_i(data_i), .rdata_i(rdata_i), .supply_o(supply_o),
        .prog_o(prog_o), .verify_o(verify_o), .blk_sel_o(blk_sel_o),
        .addr_o(addr_o), .wdata_o(wdata_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .fail_cnt_o(fail_cnt_o)
    );

    // Behavioural array: the byte at address A reads as erased (FF) until
    // A cumulative pulse cycles have been applied in the current operation.
    int cum = 0;
    always @(posedge clk) begin
        if (start_i && !busy_o) cum <= 0;
        else if (prog_o)        cum <= cum + 1;
    end
    assign rdata_i = (cum >= int'(addr_o)) ? wdata_o : 8'hFF;

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected values for the running operation, set before its start.
    int exp_k, exp_fail, exp_addr;
    bit exp_pass;
    int exp_len[8];

    task automatic plan_op(input int a, input logic [7:0] dat);
        int l, sum;
        l = INIT; sum = 0; exp_k = 0; exp_pass = 1'b0;
        for (int i = 0; i < MAXV; i++) begin
            exp_len[i] = l;
            sum += l;
            exp_k = i + 1;
            if (sum >= a || dat == 8'hFF) begin
                exp_pass = 1'b1;
                break;
            end
            l = (2 * l > LMAX) ? LMAX : 2 * l;
        end
        exp_fail = exp_pass ? exp_k - 1 : MAXV;
        exp_addr = a;
    endtask

    // Port monitor, sampling on the falling edge.
    int  cyc = 0;
    logic pprog = 0, pvfy = 0, psup = 0, pbusy = 0;
    logic [NBLK-1:0] pblk = '0;
    int  np, cur, nv, vlen, vbad, overlap, setup_cnt, vfall, bfall, sfall;
    bit  sel_seen, pend_idle = 0, op_done = 0;
    logic [NBLK-1:0] blk_seen;

    always @(negedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            chk(1'b0, "watchdog", cyc, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
        if (rst_n) begin
            if (pend_idle) begin
                chk(!busy_o && !done_o && !err_o, "R11 idle after flag",
                    int'(busy_o), 0);
                pend_idle = 0;
            end
            if (busy_o && !pbusy) begin
                np = 0; cur = 0; nv = 0; vlen = 0; vbad = 0; overlap = 0;
                setup_cnt = 0; vfall = -1; bfall = -1; sfall = -1;
                sel_seen = 0; blk_seen = '0;
                chk(fail_cnt_o == '0, "R6 count clear at start", int'(fail_cnt_o), 0);
            end
            if (busy_o) begin
                if (!sel_seen && supply_o && blk_sel_o == '0) setup_cnt++;
                if (!sel_seen && blk_sel_o != '0) begin
                    sel_seen = 1;
                    blk_seen = blk_sel_o;
                end
                if (prog_o && (verify_o || (!pprog && pvfy))) overlap++;
                if (prog_o) cur++;
                if (!prog_o && pprog) begin
                    if (np < 8) exp_len[7] = exp_len[7];
                    if (np < 8) lens[np] = cur;
                    np++;
                    cur = 0;
                end
                if (verify_o) vlen++;
                if (!verify_o && pvfy) begin
                    nv++;
                    if (vlen != VFY) vbad++;
                    vlen = 0;
                    vfall = cyc;
                end
                if (pblk != '0 && blk_sel_o == '0) bfall = cyc;
                if (psup && !supply_o) sfall = cyc;
            end
            if (done_o || err_o) begin
                // R5 / R8 outcome
                chk(done_o == exp_pass && err_o == !exp_pass,
                    exp_pass ? "R5 pass outcome" : "R8 error outcome",
                    int'(done_o), int'(exp_pass));
                chk(int'(fail_cnt_o) == exp_fail, "R6 failure count",
                    int'(fail_cnt_o), exp_fail);
                chk(np == exp_k, "R8 pulse count", np, exp_k);
                chk(nv == exp_k, "R5 verify count", nv, exp_k);
                chk(vbad == 0, "R5 verify length", vbad, 0);
                chk(overlap == 0, "R7 verify low before pulse", overlap, 0);
                chk(setup_cnt == SETUP, "R2 supply settle", setup_cnt, SETUP);
                chk(blk_seen == NBLK'(1 << (exp_addr >> (AW - 2))),
                    "R2 block select", int'(blk_seen), 1 << (exp_addr >> (AW - 2)));
                if (np > 0) chk(lens[0] == INIT, "R3 first pulse", lens[0], INIT);
                for (int i = 1; i < np && i < 8; i++)
                    chk(lens[i] == exp_len[i], "R4 doubled pulse", lens[i], exp_len[i]);
                if (exp_pass) begin
                    chk(bfall == vfall + 1 && sfall == vfall + 2 && cyc == vfall + 3,
                        "R9 release order", cyc - vfall, 3);
                end else begin
                    chk(bfall == sfall && cyc == sfall + 1,
                        "R10 error release", cyc - sfall, 1);
                end
                pend_idle = 1;
                op_done = 1;
            end
        end
        pprog = prog_o; pvfy = verify_o; psup = supply_o;
        pblk = blk_sel_o; pbusy = busy_o;
    end

    int lens[8];

    task automatic run_op(input int a, input bit stray);
        logic [7:0] dat;
        dat = 8'(a) ^ 8'h5A;
        plan_op(a, dat);
        @(posedge clk); #1;
        addr_i = AW'(a); data_i = dat; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        if (stray) begin
            // R12: strobe with another address while busy
            repeat (5) @(posedge clk);
            #1;
            addr_i = ~AW'(a); data_i = 8'h00; start_i = 1'b1;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        while (!op_done) @(posedge clk);
        #1 op_done = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!supply_o && !prog_o && !verify_o && blk_sel_o == '0 && !busy_o &&
            !done_o && !err_o && fail_cnt_o == '0, "R1 reset state",
            int'(busy_o), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !supply_o && fail_cnt_o == '0, "R1 idle after reset",
            int'(supply_o), 0);
        for (int a = 0; a < (1 << AW); a++) begin
            run_op(a, (a % 8) == 3);
        end
        repeat (3) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule